// File: doc/BRIEF.md
# Shared Request/Response Mailbox

This block sits between a host-side agent and an embedded processor. Both sides use one shared word memory through two separate synchronous ports on a common clock, and either port can read or write in any cycle. The lower half of the memory holds the request frame and the upper half holds the response frame. Every exchange is a single request followed by a single response.

The host fills the request frame. Its write to the final request word marks the frame complete. That write raises a pending flag and an interrupt line to the processor. The processor reads the request, writes its answer into the response half, and finishes with the final response word. That write drops the pending flag and the interrupt, which tells the host the answer is ready. If the host completes a new request while one is still pending, the new frame is stored anyway and a sticky overrun bit records the event.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, `pending`, `irq` and `overrun` are all 0.
- R2: Each port stores `*_wdata` at `*_addr` when `*_en` and `*_we` are both high. Every enabled access, read or write, presents on that port's `*_rdata` one cycle later the word's content from before any write in the access cycle (read-first, on both ports).
- R3: A host write to word 31 (DEPTH/2-1, the last request word) sets `pending` and `irq` from the next cycle.
- R4: A processor write to word 63 (DEPTH-1, the last response word) clears `pending` and `irq` from the next cycle.
- R5: When both ports write the same word in the same cycle, the host's data is stored.
- R6: A host write to word 31 while `pending` is already 1 sets `overrun` from the next cycle. The new data is stored. `overrun` stays 1 until reset, including across completion.
- R7: If a host write to word 31 and a processor write to word 63 occur in the same cycle, `pending` ends up 1.
- R8: Writes to any other word have no effect on `pending`, `irq` or `overrun`. This includes a host write to word 63 and a processor write to word 31.
- R9: The two ports can access different words in the same cycle, and both accesses complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset of the handshake state |
| h_en | input | 1 | Host port access enable |
| h_we | input | 1 | Host port write enable |
| h_addr | input | 6 | Host port word address |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data, one cycle after access |
| p_en | input | 1 | Processor port access enable |
| p_we | input | 1 | Processor port write enable |
| p_addr | input | 6 | Processor port word address |
| p_wdata | input | 32 | Processor port write data |
| p_rdata | output | 32 | Processor port read data, one cycle after access |
| irq | output | 1 | Interrupt to the processor; high while a request waits |
| pending | output | 1 | Wait flag seen by the host |
| overrun | output | 1 | Sticky: a request was completed while another was pending |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it. Read data and the three status bits all come from a single register stage. The driver applies an access at a falling edge and pushes the expected read words for each enabled port into per-port queues. The expected words are taken from a bench memory model before that cycle's writes are applied. The monitor records which ports were enabled at the next rising edge, waits 2 ns, and then pops and compares `h_rdata` and `p_rdata`. The status bits are compared against a bench flag model at the falling edge that ends each access cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Index of the word that closes the request half of a DEPTH-word memory.
  function automatic logic closes_request(input int unsigned addr, input int unsigned depth);
    return addr == (depth / 2) - 1;
  endfunction

  // Index of the word that closes the response half.
  function automatic logic closes_response(input int unsigned addr, input int unsigned depth);
    return addr == depth - 1;
  endfunction

  // Next value of the pending flag given completion events.
  function automatic logic next_pending(input logic cur, input logic req_evt, input logic rsp_evt);
    if (req_evt) return 1'b1;
    if (rsp_evt) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Port A is the priority port on a same-word double write.
  logic a_write, b_write, collide;
  assign a_write = a_en && a_we;
  assign b_write = b_en && b_we;
  assign collide = a_write && b_write && (a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (a_en) a_rdata <= mem[a_addr];
    if (b_en) b_rdata <= mem[b_addr];
    if (b_write && !collide) mem[b_addr] <= b_wdata;
    if (a_write) mem[a_addr] <= a_wdata;
  end

  // R5: on a same-word double write the priority port's data lands.
  assert_host_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> mem[$past(a_addr)] == $past(a_wdata));

  // R2: a lone write from port B is stored.
  assert_b_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (b_write && !collide) |=> mem[$past(b_addr)] == $past(b_wdata));

endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              p_write,
  input  logic [ADDR_W-1:0] p_addr,
  output logic              req_done,
  output logic              rsp_done,
  output logic              pending,
  output logic              irq,
  output logic              overrun
);

  assign req_done = h_write && closes_request(int'(h_addr), DEPTH);
  assign rsp_done = p_write && closes_response(int'(p_addr), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      pending <= next_pending(pending, req_done, rsp_done);
      irq     <= next_pending(irq, req_done, rsp_done);
      if (req_done && pending) overrun <= 1'b1;
    end
  end

  assert_req_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (pending && irq));

  assert_rsp_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !req_done) |=> (!pending && !irq));

  assert_overrun_on_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && pending) |=> overrun);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && rsp_done) |=> pending);

  assert_quiet_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_done && !rsp_done) |=> ($stable(pending) && $stable(irq) && $stable(overrun)));

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_en,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              p_en,
  input  logic              p_we,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [DATA_W-1:0] p_rdata,
  output logic              irq,
  output logic              pending,
  output logic              overrun
);

  logic h_write, p_write, req_done, rsp_done;
  assign h_write = h_en && h_we;
  assign p_write = p_en && p_we;

  mbx_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(h_en), .a_we(h_we), .a_addr(h_addr), .a_wdata(h_wdata), .a_rdata(h_rdata),
    .b_en(p_en), .b_we(p_we), .b_addr(p_addr), .b_wdata(p_wdata), .b_rdata(p_rdata)
  );

  mbx_handshake #(.DEPTH(DEPTH)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .h_write(h_write), .h_addr(h_addr),
    .p_write(p_write), .p_addr(p_addr),
    .req_done(req_done), .rsp_done(rsp_done),
    .pending(pending), .irq(irq), .overrun(overrun)
  );

  // R1: flags are low on the first cycle after reset.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!pending && !irq && !overrun));

endmodule

// File: tb/cmd_mailbox_bench.sv
`timescale 1ns/1ps
module cmd_mailbox_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_en = 0, h_we = 0, p_en = 0, p_we = 0;
  logic [5:0] h_addr = 0, p_addr = 0;
  logic [31:0] h_wdata = 0, p_wdata = 0;
  logic [31:0] h_rdata, p_rdata;
  logic irq, pending, overrun;

  always #4 clk = ~clk;

  cmd_mailbox u_cmd_mailbox (
    .clk(clk), .rst_n(rst_n),
    .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .p_en(p_en), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .irq(irq), .pending(pending), .overrun(overrun)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // Bench memory model and flag model.
  logic [31:0] mdl [64];
  bit          mdl_ok [64];
  bit e_pend = 0, e_ovr = 0;

  // Scoreboard queues: {known, data} and requirement tag per port.
  logic [32:0] qh [$];
  logic [32:0] qp [$];
  string th [$];
  string tp [$];

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    cmp(tag, "pending", {31'd0, pending}, {31'd0, e_pend});
    cmp(tag, "irq", {31'd0, irq}, {31'd0, e_pend});
    cmp(tag, "overrun", {31'd0, overrun}, {31'd0, e_ovr});
  endtask

  // One access cycle on both ports; called at a falling edge.
  task automatic op(input logic he, input logic hw, input logic [5:0] ha, input logic [31:0] hd,
                    input logic pe, input logic pw, input logic [5:0] pa, input logic [31:0] pd,
                    input string tag);
    bit rq, rs;
    h_en = he; h_we = hw; h_addr = ha; h_wdata = hd;
    p_en = pe; p_we = pw; p_addr = pa; p_wdata = pd;
    if (he) begin qh.push_back({mdl_ok[ha], mdl[ha]}); th.push_back(tag); end
    if (pe) begin qp.push_back({mdl_ok[pa], mdl[pa]}); tp.push_back(tag); end
    if (pe && pw) begin mdl[pa] = pd; mdl_ok[pa] = 1; end
    if (he && hw) begin mdl[ha] = hd; mdl_ok[ha] = 1; end
    rq = he && hw && (ha == 6'd31);
    rs = pe && pw && (pa == 6'd63);
    if (rq) begin if (e_pend) e_ovr = 1; e_pend = 1; end
    else if (rs) e_pend = 0;
    @(negedge clk);
    h_en = 0; h_we = 0; p_en = 0; p_we = 0;
    chk_flags(tag);
  endtask

  // Monitor: ports enabled at a rising edge show data 2 ns later.
  logic mh, mp;
  logic [32:0] eh, ep;
  string sh, sp;
  always @(posedge clk) begin
    mh = h_en; mp = p_en;
    #2;
    if (mh) begin
      eh = qh.pop_front(); sh = th.pop_front();
      if (eh[32]) cmp(sh, "h_rdata", h_rdata, eh[31:0]);
    end
    if (mp) begin
      ep = qp.pop_front(); sp = tp.pop_front();
      if (ep[32]) cmp(sp, "p_rdata", p_rdata, ep[31:0]);
    end
  end

  function automatic logic [31:0] pat(input int i, input int salt);
    return 32'hA5000000 ^ (i * 32'h01010101) ^ (salt << 20);
  endfunction

  task automatic do_reset(input string tag);
    rst_n = 0; e_pend = 0; e_ovr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_flags(tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl_ok[i] = 0;
    @(negedge clk);
    do_reset("R1");

    // Host fills the request; flags rise only on word 31.
    for (int i = 0; i < 32; i++)
      op(1, 1, 6'(i), pat(i, 1), 0, 0, 0, 0, (i == 31) ? "R3" : "R8");
    // Processor reads request while host fills nothing.
    for (int i = 0; i < 32; i++) op(0, 0, 0, 0, 1, 0, 6'(i), 0, "R2");
    // Processor writes response; last word clears.
    for (int i = 32; i < 64; i++)
      op(0, 0, 0, 0, 1, 1, 6'(i), pat(i, 2), (i == 63) ? "R4" : "R8");
    // Both ports read different words in the same cycle.
    for (int i = 0; i < 32; i++) op(1, 0, 6'(32 + i), 0, 1, 0, 6'(i), 0, "R9");

    // Same-word double write, then read back from both ports.
    op(1, 1, 6'd5, 32'h1111_2222, 1, 1, 6'd5, 32'h3333_4444, "R5");
    op(1, 0, 6'd5, 0, 1, 0, 6'd5, 0, "R5");

    // Read-first on the same port and across ports.
    op(1, 1, 6'd7, 32'hDEAD_0007, 1, 0, 6'd7, 0, "R2");
    op(0, 0, 0, 0, 1, 1, 6'd8, 32'hBEEF_0008, "R2");
    op(1, 0, 6'd8, 0, 1, 0, 6'd7, 0, "R2");

    // Cross-half closing words do not touch flags.
    op(1, 1, 6'd63, 32'h0000_0063, 1, 1, 6'd31, 32'h0000_0031, "R8");

    // Set and clear in the same cycle: set wins.
    op(1, 1, 6'd31, 32'h7777_0031, 1, 1, 6'd63, 32'h7777_0063, "R7");
    op(0, 0, 0, 0, 1, 1, 6'd63, 32'h0, "R4");

    // Overrun: second request while pending, data still stored.
    op(1, 1, 6'd31, 32'hC0DE_0001, 0, 0, 0, 0, "R3");
    op(1, 1, 6'd31, 32'hC0DE_0002, 0, 0, 0, 0, "R6");
    op(0, 0, 0, 0, 1, 0, 6'd31, 0, "R6");
    op(0, 0, 0, 0, 1, 1, 6'd63, 32'h1, "R6");
    op(1, 0, 6'd63, 0, 0, 0, 0, 0, "R6");

    repeat (2) @(negedge clk);
    cmp("R2", "queues drained", 32'(qh.size() + qp.size()), 32'd0);
    do_reset("R1");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule